// File: doc/BRIEF.md
# Four-level multi-carrier PWM gate generator

This block drives the ten power switches of a single-phase, four-level inverter built from two full bridges that share their output terminals, plus a pair of switches that tie the middle of the DC bus to the output. It receives a signed modulating sample once per clock and compares it against three stacked triangular carriers, all derived from one internal up/down counter. The comparison picks one of four output levels (double positive, positive, negative, double negative). A fixed table turns the chosen level into a gate pattern.

The gate stage releases any switch that must turn off on the first edge after a level change. It keeps every switch that must turn on low for a programmable dead-time count. The modulating sample is captured only at the carrier peak and valley, so one carrier ramp always works on one stable value. Driving enable low, or asserting reset, turns every switch off.

Top module: `mc4_pwm_gate`

## Requirements
- R1: The carrier counter follows the sequence 0,1,...,P,P-1,...,1,0,1,... where P is `period_i` captured whenever the counter is 0. A captured value of 0 is treated as 1. While `en_i` is low the counter is held at 0 and set to count up.
- R2: Let m be the held sample, c the counter and P the captured period. In doubled units the three carriers are 2c-3P, 2c-P and 2c+P. One clock after a counter value is seen, `lvl_o` equals the number of carriers strictly below 2m, so 2m>P gives level 3 or 2, -P<2m<=P gives 2 or 1, and 2m<=-P gives 1 or 0.
- R3: The held sample is reloaded from `sample_i` only on edges where the counter is 0 or equal to P. A sample value present only mid-ramp never reaches `lvl_o`.
- R4: The gate patterns are as follows. Level 3 sets bits 0 and 3 (10'h009). Level 0 sets bits 1 and 2 (10'h006). Level 2 sets bits 4, 7, 8 and 9 (10'h390). Level 1 sets bits 5, 6, 8 and 9 (10'h360). The outer bridge uses bits 3:0, the inner bridge uses bits 7:4, and the middle-bus pair uses bits 9:8.
- R5: `lvl_o` encodes 11 for double positive, 10 for positive, 01 for negative and 00 for double negative. It reads 00 after reset and one clock after `en_i` goes low.
- R6: On the first edge after `lvl_o` changes, every gate that is absent from the new pattern goes low. No gate rises on that edge. Gates of the new pattern that were off rise exactly D edges later, where D is `dead_i` at the change edge and a value of 0 is treated as 1. No edge both raises one gate and lowers another.
- R7: During reset, and one clock after `en_i` goes low, all ten gates are low. After enable returns, gates first turn on only after a full dead time.
- R8: No bridge leg ever has both of its switches on. The leg pairs are bits 0/1, 2/3, 4/5 and 6/7. `sw_o` is always one of the four patterns, their common part 10'h300, or zero.
- R9: A level change during a dead-time wait restarts the wait for the newest level. Only gates common to every level seen since the last settled pattern stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low forces all gates off |
| sample_i | input | DATA_W | Signed modulating sample |
| period_i | input | PER_W | Carrier half-period in clocks |
| dead_i | input | DT_W | Dead-time count in clocks |
| sw_o | output | 10 | Gate outputs (bit map in R4) |
| lvl_o | output | 2 | Selected level code (R5) |

## Verification
The assertions assume that reset is asserted from the first clock and that `en_i`, `period_i` and `dead_i` change only between edges. They also assume that sample magnitudes stay within the signed range, so the doubled comparison cannot wrap. The stimulus drives every input on falling edges and keeps sample values small next to the full scale. It varies the period, including 0 and 1, and the dead time, including 0. It sweeps the sample slowly through all three bands and also forces a level change on every clock, so the restart rule is exercised.

// File: rtl/mc4_pkg.sv
package mc4_pkg;
  localparam int NSW  = 10;
  localparam int NCAR = 3;

  typedef enum logic [1:0] {
    LVL_NN = 2'b00,
    LVL_N  = 2'b01,
    LVL_P  = 2'b10,
    LVL_PP = 2'b11
  } lvl_t;

  // outer bridge bits 3:0, inner bridge bits 7:4, middle-bus pair bits 9:8
  function automatic logic [NSW-1:0] sw_map(input lvl_t l);
    logic [NSW-1:0] r;
    case (l)
      LVL_PP:  r = 10'h009;
      LVL_P:   r = 10'h390;
      LVL_N:   r = 10'h360;
      default: r = 10'h006;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mc4_carrier.sv
module mc4_carrier #(
  parameter int PER_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     en_i,
  input  logic [PER_W-1:0]         period_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic [PER_W-1:0]         cnt_o,
  output logic [PER_W-1:0]         per_o,
  output logic signed [DATA_W-1:0] samp_o
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0]         cnt_q, per_q;
  logic                     up_q;
  logic signed [DATA_W-1:0] samp_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      per_q  <= ONE;
      samp_q <= '0;
    end else begin
      // period is taken only at the valley so a ramp never changes length
      if (cnt_q == '0)
        per_q <= (period_i == '0) ? ONE : period_i;
      // sample is taken only at the extremes of the triangle
      if (cnt_q == '0 || cnt_q == per_q)
        samp_q <= sample_i;
      if (!en_i) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else if (up_q) begin
        if (cnt_q >= per_q) begin
          up_q  <= 1'b0;
          cnt_q <= cnt_q - ONE;
        end else begin
          cnt_q <= cnt_q + ONE;
        end
      end else if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign samp_o = samp_q;
endmodule

// File: rtl/mc4_slicer.sv
module mc4_slicer #(
  parameter int PER_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     en_i,
  input  logic [PER_W-1:0]         cnt_i,
  input  logic [PER_W-1:0]         per_i,
  input  logic signed [DATA_W-1:0] samp_i,
  output logic [1:0]               lvl_o
);
  import mc4_pkg::*;

  localparam int CW = ((DATA_W > PER_W) ? DATA_W : PER_W) + 4;

  logic signed [CW-1:0] m2, c2, ps;
  logic [NCAR-1:0]      above;
  logic [1:0]           lvl_q;

  assign m2 = $signed({{(CW-DATA_W){samp_i[DATA_W-1]}}, samp_i}) <<< 1;
  assign c2 = $signed({{(CW-PER_W){1'b0}}, cnt_i}) <<< 1;
  assign ps = $signed({{(CW-PER_W){1'b0}}, per_i});

  // carrier k sits at offset (2k-3)*P in doubled units: lower, middle, upper
  for (genvar k = 0; k < NCAR; k++) begin : g_car
    localparam logic signed [CW-1:0] OFS = CW'(2 * k - 3);
    logic signed [CW-1:0] thr;
    assign thr      = c2 + OFS * ps;
    assign above[k] = (m2 > thr);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) lvl_q <= 2'b00;
    else                lvl_q <= 2'($countones(above));
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/mc4_deadtime.sv
module mc4_deadtime #(
  parameter int DT_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     en_i,
  input  logic [1:0]               lvl_i,
  input  logic [DT_W-1:0]          dead_i,
  output logic [mc4_pkg::NSW-1:0]  sw_o
);
  import mc4_pkg::*;

  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  logic [NSW-1:0]  sw_q;
  logic [1:0]      app_q;
  logic [DT_W-1:0] wait_q;
  logic            armed_q;
  logic            changed;

  assign changed = !armed_q || (lvl_i != app_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      sw_q    <= '0;
      app_q   <= 2'b00;
      wait_q  <= '0;
      armed_q <= 1'b0;
    end else if (changed) begin
      // break first: keep only gates shared with the new pattern
      armed_q <= 1'b1;
      app_q   <= lvl_i;
      wait_q  <= (dead_i == '0) ? ONE : dead_i;
      sw_q    <= sw_q & sw_map(lvl_t'(lvl_i));
    end else if (wait_q != '0) begin
      wait_q <= wait_q - ONE;
      if (wait_q == ONE) sw_q <= sw_map(lvl_t'(app_q));
    end
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/mc4_pwm_gate.sv
module mc4_pwm_gate #(
  parameter int DATA_W = 16,
  parameter int PER_W  = 12,
  parameter int DT_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [PER_W-1:0]         period_i,
  input  logic [DT_W-1:0]          dead_i,
  output logic [mc4_pkg::NSW-1:0]  sw_o,
  output logic [1:0]               lvl_o
);
  logic [PER_W-1:0]         cnt, per;
  logic signed [DATA_W-1:0] samp;
  logic [1:0]               lvl;

  mc4_carrier #(.PER_W(PER_W), .DATA_W(DATA_W)) u_car (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
    .period_i(period_i), .sample_i(sample_i),
    .cnt_o(cnt), .per_o(per), .samp_o(samp)
  );

  mc4_slicer #(.PER_W(PER_W), .DATA_W(DATA_W)) u_slc (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
    .cnt_i(cnt), .per_i(per), .samp_i(samp), .lvl_o(lvl)
  );

  mc4_deadtime #(.DT_W(DT_W)) u_dt (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i),
    .lvl_i(lvl), .dead_i(dead_i), .sw_o(sw_o)
  );

  assign lvl_o = lvl;
endmodule

// File: rtl/mc4_pwm_gate_chk.sv
module mc4_pwm_gate_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       en_i,
  input logic [9:0] sw_o,
  input logic [1:0] lvl_o
);
  assert_gates_off_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (sw_o == 10'h000));

  assert_code_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (lvl_o == 2'b00));

  assert_legal_pattern_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (sw_o == 10'h000 || sw_o == 10'h009 || sw_o == 10'h006 ||
     sw_o == 10'h390 || sw_o == 10'h360 || sw_o == 10'h300));

  assert_no_leg_short_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !(sw_o[0] && sw_o[1]) && !(sw_o[2] && sw_o[3]) &&
    !(sw_o[4] && sw_o[5]) && !(sw_o[6] && sw_o[7]));

  assert_break_before_make_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ((sw_o & ~$past(sw_o)) != 10'h000) |-> (($past(sw_o) & ~sw_o) == 10'h000));

  assert_no_rise_on_change_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (lvl_o != $past(lvl_o)) |=> ((sw_o & ~$past(sw_o)) == 10'h000));
endmodule

bind mc4_pwm_gate mc4_pwm_gate_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .sw_o(sw_o), .lvl_o(lvl_o)
);

// File: tb/mc4_pwm_gate_tb.sv
`timescale 1ns/1ps
module mc4_pwm_gate_tb;
  localparam int DATA_W = 16;
  localparam int PER_W  = 12;
  localparam int DT_W   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [DATA_W-1:0] sample = '0;
  logic [PER_W-1:0] period = PER_W'(8);
  logic [DT_W-1:0]  dead   = DT_W'(2);
  logic [9:0] sw;
  logic [1:0] lvl;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  bit live  = 0;

  // reference model state
  int mc, mup, mper, msamp, mlvl, mapp, marm, mwait;
  logic [9:0] msw;

  mc4_pwm_gate #(.DATA_W(DATA_W), .PER_W(PER_W), .DT_W(DT_W)) u_dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .sample_i(sample),
    .period_i(period), .dead_i(dead), .sw_o(sw), .lvl_o(lvl)
  );

  always #2.5 clk = ~clk;

  function automatic logic [9:0] pattern(input int l);
    case (l)
      3: return 10'h009;
      2: return 10'h390;
      1: return 10'h360;
      default: return 10'h006;
    endcase
  endfunction

  function automatic int band_level(input int m, input int c, input int p);
    int m2;
    m2 = 2 * m;
    if (m2 > p)       return (m2 > 2*c + p)   ? 3 : 2;
    else if (m2 > -p) return (m2 > 2*c - p)   ? 2 : 1;
    else              return (m2 > 2*c - 3*p) ? 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural model, updated in reverse pipeline order from old values
  always @(posedge clk) begin
    int c0, p0, d;
    live = 1;
    if (rst) begin
      mc = 0; mup = 1; mper = 1; msamp = 0; mlvl = 0;
      mapp = 0; marm = 0; mwait = 0; msw = '0;
    end else begin
      if (!en) begin
        msw = '0; mapp = 0; marm = 0; mwait = 0;
      end else if (!marm || mlvl != mapp) begin
        d = (dead == 0) ? 1 : int'(dead);
        marm = 1; mapp = mlvl; mwait = d;
        msw = msw & pattern(mlvl);
      end else if (mwait > 0) begin
        if (mwait == 1) msw = pattern(mapp);
        mwait--;
      end
      c0 = mc; p0 = mper;
      mlvl = en ? band_level(msamp, c0, p0) : 0;
      if (c0 == 0 || c0 == p0) msamp = int'(sample);
      if (c0 == 0) mper = (period == 0) ? 1 : int'(period);
      if (!en) begin mc = 0; mup = 1; end
      else if (mup != 0) begin
        if (c0 >= p0) begin mup = 0; mc = c0 - 1; end else mc = c0 + 1;
      end else if (c0 == 0) begin mup = 1; mc = 1; end
      else mc = c0 - 1;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk(int'(lvl) == mlvl, "R1 R2 R3 R5 level", int'(lvl), mlvl);
      chk(sw == msw, "R4 R6 R7 R9 gates", int'(sw), int'(msw));
      chk(!(sw[0]&&sw[1]) && !(sw[2]&&sw[3]) && !(sw[4]&&sw[5]) && !(sw[6]&&sw[7]),
          "R8 leg short", int'(sw), 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(5);
    chk(sw == 10'h000, "R7 reset gates", int'(sw), 0);
    chk(lvl == 2'b00, "R5 reset level", int'(lvl), 0);
    rst = 1'b0;
    en  = 1'b1;
    step(1);
    chk(sw == 10'h000, "R7 first enable gates", int'(sw), 0);

    // slow sweep through all bands, period 8, dead 2
    for (int i = 0; i < 2400; i++) begin
      sample = DATA_W'(((i / 20) % 34) - 17);
      step(1);
    end

    // steady extremes
    sample = 16'sd100;
    step(40);
    chk(lvl == 2'b11, "R4 R5 top level", int'(lvl), 3);
    chk(sw == 10'h009, "R4 top pattern", int'(sw), 'h009);
    sample = -16'sd100;
    step(40);
    chk(lvl == 2'b00, "R4 R5 bottom level", int'(lvl), 0);
    chk(sw == 10'h006, "R4 bottom pattern", int'(sw), 'h006);

    // mid-ramp glitch on the sample is never captured
    while (!(mc == 3 && mup != 0)) step(1);
    sample = 16'sd100;
    step(1);
    sample = -16'sd100;
    for (int i = 0; i < 20; i++) begin
      step(1);
      chk(lvl == 2'b00, "R3 mid-ramp sample ignored", int'(lvl), 0);
    end

    // disable mid-run
    sample = 16'sd100;
    step(30);
    en = 1'b0;
    step(1);
    chk(sw == 10'h000, "R7 gates after disable", int'(sw), 0);
    chk(lvl == 2'b00, "R5 level after disable", int'(lvl), 0);
    step(5);
    en = 1'b1;
    step(1);
    chk(sw == 10'h000, "R7 gates right after re-enable", int'(sw), 0);

    // dead time 0 and shorter period
    dead   = '0;
    period = PER_W'(5);
    for (int i = 0; i < 1500; i++) begin
      sample = DATA_W'(((i / 13) % 22) - 11);
      step(1);
    end

    // level flips on every clock: wait restarts, bridge gates never rise
    period = PER_W'(1);
    dead   = DT_W'(3);
    sample = '0;
    step(20);
    for (int i = 0; i < 30; i++) begin
      step(1);
      chk(sw[7:0] == 8'h00, "R9 restart keeps bridges off", int'(sw), int'(sw & 10'h300));
    end

    // period 0 behaves as 1, then a long period
    period = '0;
    dead   = DT_W'(1);
    for (int i = 0; i < 400; i++) begin
      sample = DATA_W'(((i / 7) % 10) - 5);
      step(1);
    end
    period = PER_W'(20);
    for (int i = 0; i < 3000; i++) begin
      sample = DATA_W'(((i / 40) % 70) - 35);
      step(1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule